// File: doc/BRIEF.md
# Timestamp-Compare Periodic Output Generator

One channel of a periodic output generator slaved to a free-running 64-bit nanosecond time value that arrives on an input port. Software writes an absolute 64-bit start time as two 32-bit words and then a period expressed in reference-clock cycles. The channel compares the incoming time against the start time. Once the time has reached it, the channel produces a square wave on `out_o` whose period is the programmed cycle count. The wave continues until the length is rewritten.

A length of zero is the off switch. The intended programming order is: length to zero, compare high word, compare low word, and finally the nonzero length. Writing the nonzero length is what arms the channel, so the compare words are always complete before arming. A full system instantiates several of these channels side by side. The time counter, interrupts and clock-domain crossing live outside this block.

Top module: `perout_gen`

## Requirements
- R1: After reset `out_o` is low, the stored length is zero, and the channel stays low whatever `time_i` does until a nonzero length is written.
- R2: Writes go to a word selected by `wr_addr_i`: 0 selects the low 32 bits of the start time, 1 selects the high 32 bits, and 2 selects the length. The start time is {high, low} and both halves take part in the compare. Writes to address 3 change nothing.
- R3: A write of a nonzero length arms the channel. While armed and `time_i` < start time, `out_o` stays low.
- R4: A clock edge on which the channel is armed, no length write occurs, and `time_i` >= start time (unsigned, so a time already past the start also counts) starts the channel. `out_o` is high right after that edge.
- R5: Once started, `out_o` repeats with a period of exactly `length` cycles. Each period opens with a high phase of length − floor(length/2) cycles, followed by a low phase of floor(length/2) cycles.
- R6: With length 1, `out_o` stays high every cycle after the start.
- R7: A write of zero to the length drives `out_o` low right after that write's edge and clears the started state. It then stays low regardless of `time_i`.
- R8: Any length write during a run stops the run at that edge, with `out_o` low after it. A nonzero value re-arms the channel, which waits for a fresh compare match and restarts at the beginning of a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word select |
| wr_data_i | input | 32 | Register write data |
| time_i | input | 64 | Current time in nanoseconds |
| out_o | output | 1 | Periodic output |

## Verification
The embedded properties hold on every cycle for the following rules:
- a zero-length write forces the output low on the next cycle;
- a start only ever follows an armed state;
- a match while armed always starts the channel;
- the phase counter stays below the length;
- a length of 1 holds the output high;
- a write to the unused address leaves every register stable.

Only the bench scenarios can show the following:
- the exact high/low waveform over whole periods for a spread of odd and even lengths;
- that the high compare word really gates the start;
- that a re-armed channel waits for a fresh match and restarts at the top of a high phase.

// File: rtl/perout_pkg.sv
package perout_pkg;
  typedef enum logic [1:0] {
    SEL_CMP_LO = 2'd0,
    SEL_CMP_HI = 2'd1,
    SEL_LEN    = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/perout_regs.sv
module perout_regs #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [TIME_W-1:0] cmp_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              len_wr_o,
  output logic              arm_req_o
);
  import perout_pkg::*;
  localparam int NWORDS = TIME_W / DATA_W;

  logic [LEN_W-1:0] len_q;

  // compare words, word w at address w
  for (genvar w = 0; w < NWORDS; w++) begin : g_cmp
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q <= '0;
      else if (wr_en_i && (wr_addr_i == 2'(w)))
        word_q <= wr_data_i;
    end
    assign cmp_o[w*DATA_W +: DATA_W] = word_q;
  end

  assign len_wr_o  = wr_en_i && (wr_addr_i == SEL_LEN);
  assign arm_req_o = len_wr_o && (wr_data_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        len_q <= '0;
    else if (len_wr_o)  len_q <= LEN_W'(wr_data_i);
  end
  assign len_o = len_q;

  // R2
  rsvd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_RSVD) |=> ($stable(cmp_o) && $stable(len_o)));
endmodule

// File: rtl/perout_arm.sv
module perout_arm #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] cmp_i,
  input  logic              len_wr_i,
  input  logic              arm_req_i,
  output logic              run_o
);
  logic armed_q, started_q, time_ge;

  assign time_ge = (time_i >= cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      started_q <= 1'b0;
    end else if (len_wr_i) begin
      // any length write stops the run; nonzero re-arms
      armed_q   <= arm_req_i;
      started_q <= 1'b0;
    end else if (armed_q && time_ge) begin
      armed_q   <= 1'b0;
      started_q <= 1'b1;
    end
  end
  assign run_o = started_q;

  // R3
  start_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started_q) |-> $past(armed_q));
  // R4
  match_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && time_ge && !len_wr_i) |=> started_q);
endmodule

// File: rtl/perout_phase.sv
module perout_phase #(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             out_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, hi_len;

  assign hi_len = len_i - (len_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i)                cnt_q <= '0;
    else if (cnt_q == len_i - ONE)  cnt_q <= '0;
    else                            cnt_q <= cnt_q + ONE;
  end

  assign out_o = run_i && (cnt_q < hi_len);

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_i));
  // R6
  len_one_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && len_i == ONE) |-> out_o);
endmodule

// File: rtl/perout_gen.sv
module perout_gen #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              out_o
);
  import perout_pkg::*;

  logic [TIME_W-1:0] cmp;
  logic [LEN_W-1:0]  len;
  logic              len_wr, arm_req, run;

  perout_regs #(.DATA_W(DATA_W), .TIME_W(TIME_W), .LEN_W(LEN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cmp_o(cmp), .len_o(len), .len_wr_o(len_wr),
    .arm_req_o(arm_req)
  );

  perout_arm #(.TIME_W(TIME_W)) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_i), .cmp_i(cmp),
    .len_wr_i(len_wr), .arm_req_i(arm_req), .run_o(run)
  );

  perout_phase #(.LEN_W(LEN_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .len_i(len), .out_o(out_o)
  );

  // R7
  zero_len_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_LEN && wr_data_i == '0) |=> !out_o);
endmodule

// File: tb/sim_perout_gen.sv
module sim_perout_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_v = '0;
  logic        out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  perout_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .time_i(time_v), .out_o(out)
  );

  localparam int NV = 6;
  localparam logic [31:0] LEN_TAB [NV] = '{32'd2, 32'd3, 32'd4, 32'd5, 32'd8, 32'd9};
  localparam logic [63:0] START_TAB [NV] = '{64'h0000_0000_0000_0100,
    64'h0000_0002_0000_0010, 64'h0000_0000_FFFF_FFF0, 64'h0000_0010_8000_0000,
    64'h1234_0000_0000_0040, 64'h0000_0000_0000_0001};
  localparam logic [63:0] OFS_TAB [NV] = '{64'd0, 64'd7, 64'd0, 64'd100, 64'd1, 64'd0};

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: out_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm(input logic [63:0] st, input logic [31:0] len);
    wr(2'd2, 32'd0);
    wr(2'd1, st[63:32]);
    wr(2'd0, st[31:0]);
    wr(2'd2, len);
  endtask

  // checks waveform from the first cycle after the start edge
  task automatic wave(input logic [31:0] len, input int cycles, input string req);
    for (int j = 0; j < cycles; j++) begin
      chk(out, (32'(j) % len) < (len - len / 2), req);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    time_v = '1;
    repeat (3) @(negedge clk);
    chk(out, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(out, 1'b0, "R1 idle after reset");
    end

    // table: R3 wait low, R4 start on >=, R5 period shape
    for (int v = 0; v < NV; v++) begin
      time_v = '0;
      arm(START_TAB[v], LEN_TAB[v]);
      time_v = START_TAB[v] - 64'd1;
      repeat (3) begin
        chk(out, 1'b0, "R3 armed below start");
        @(negedge clk);
      end
      time_v = START_TAB[v] + OFS_TAB[v];
      @(negedge clk);
      chk(out, 1'b1, "R4 high after match");
      wave(LEN_TAB[v], 3 * LEN_TAB[v], "R5 period");
    end

    // R2: high word gates the compare
    time_v = '0;
    arm(64'h0000_0001_0000_0000, 32'd4);
    time_v = 64'h0000_0000_FFFF_FFFF;
    repeat (3) begin
      @(negedge clk);
      chk(out, 1'b0, "R2 high word blocks start");
    end
    time_v = 64'h0000_0001_0000_0000;
    @(negedge clk);
    wave(32'd4, 8, "R2 start on full 64-bit match");

    // R2: address 3 write ignored while running (continues at phase 8)
    wr(2'd3, 32'd0);
    // wr consumed two cycles: phase index is now 10
    for (int j = 10; j < 18; j++) begin
      chk(out, (j % 4) < 2, "R2 addr 3 ignored");
      @(negedge clk);
    end

    // R6: length 1 stays high
    time_v = '0;
    arm(64'd50, 32'd1);
    time_v = 64'd50;
    @(negedge clk);
    repeat (6) begin
      chk(out, 1'b1, "R6 length 1 high");
      @(negedge clk);
    end

    // R7: zero length stops and stays low
    time_v = '0;
    arm(64'd10, 32'd4);
    time_v = 64'd20;
    @(negedge clk);
    wave(32'd4, 5, "R7 setup run");
    wr(2'd2, 32'd0);
    chk(out, 1'b0, "R7 low after zero write");
    time_v = '1;
    repeat (5) begin
      @(negedge clk);
      chk(out, 1'b0, "R7 stays low");
    end

    // R8: rewrite length mid-run re-arms and waits for match
    time_v = '0;
    arm(64'd300, 32'd5);
    time_v = 64'd300;
    @(negedge clk);
    wave(32'd5, 7, "R8 setup run");
    time_v = 64'd299;
    wr(2'd2, 32'd6);
    chk(out, 1'b0, "R8 low after rewrite");
    repeat (3) begin
      @(negedge clk);
      chk(out, 1'b0, "R8 waits for match");
    end
    time_v = 64'd300;
    @(negedge clk);
    wave(32'd6, 12, "R8 restart new period");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule